// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block breaks a multi-register memory transfer into single word accesses. The caller hands over one request. The request holds a base address, a 16-bit selection of registers, one of four stepping modes, a direction flag (load or store) and a flag that asks for the base register to be updated. The block then presents one access per selected register on a valid/ready port toward memory. Each access carries the register number, the word address and a flag that tells the memory whether the access follows on from the previous one.

All four modes issue their addresses in rising order, and each puts the lowest selected register at the lowest address. The decrementing modes work out a lowered start address once, at acceptance, and from there step upward one word at a time. After the last access the block raises a one-cycle completion pulse. The pulse carries the updated base value and echoes the update flag, so the register-file side can decide whether to write it back.

Mode encoding on `req_mode`: 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before. Bit 1 selects the decrementing direction. Bit 0 selects the "before" offset.

Top module: `lsm_addr_seq`

## Requirements
- R1: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle: no access is pending and no completion pulse is showing. Requests offered while busy have no effect on the accesses in progress.
- R2: One access is issued per set bit of `req_mask`. Accesses come in ascending register order, and `xfer_reg` gives the bit position (0 to 15).
- R3: With N set bits and aligned base B, the first address is B for mode 0, B+4 for mode 1, B-4N+4 for mode 2 and B-4N for mode 3. Arithmetic is modulo 2^32.
- R4: Each access after the first has an address exactly 4 above the previous one, so the lowest register sits at the lowest address.
- R5: The first access of a request shows `xfer_seq` = 0, and every later access of the same request shows `xfer_seq` = 1.
- R6: While `xfer_valid` is high and `xfer_ready` is low, the address, register number and sequential flag stay unchanged. An access completes only on a cycle with `xfer_ready` high.
- R7: `done` is high for exactly one cycle, the cycle after the last access completes. In that cycle `wb_value` is B+4N for modes 0 and 1 and B-4N for modes 2 and 3, and `wb_en` equals the request's writeback flag. `xfer_load` equals the request's load flag on every access.
- R8: A request with an all-zero mask issues no access. It raises `done` in the cycle after acceptance, with `wb_value` equal to B.
- R9: The two lowest bits of `req_base` are ignored. Every access address and every `wb_value` has its two lowest bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_base | input | 32 | Base address |
| req_mask | input | 16 | Register selection, bit i selects register i |
| req_mode | input | 2 | Stepping mode (encoding above) |
| req_load | input | 1 | 1 = load, 0 = store |
| req_wb | input | 1 | Base update requested |
| xfer_valid | output | 1 | Access pending toward memory |
| xfer_ready | input | 1 | Memory takes the access |
| xfer_addr | output | 32 | Word address of the access |
| xfer_reg | output | 4 | Register number of the access |
| xfer_load | output | 1 | Direction of the access |
| xfer_seq | output | 1 | 1 = follows on from previous access |
| done | output | 1 | One-cycle completion pulse |
| wb_value | output | 32 | Updated base value, valid with done |
| wb_en | output | 1 | Base update requested, valid with done |

## Verification
Each of the four modes is run with a different mask shape: sparse low bits, the two end registers, alternating nibbles and a full mask. These runs separate the start-address offsets from one another and check that ascending order holds across gaps in the mask. The memory ready line is driven with always-ready, alternating and two-on-two-off patterns. These show that a stall freezes the access rather than skipping or repeating a register, and that the sequential flag depends on the position of the access within the request, not on timing. The remaining cases cover the corners of the function: an empty mask, a single top register, an unaligned base, a decrement that wraps below address zero, and requests held high while the block is busy.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic [1:0] {
      LSM_INC_AFTER  = 2'd0,
      LSM_INC_BEFORE = 2'd1,
      LSM_DEC_AFTER  = 2'd2,
      LSM_DEC_BEFORE = 2'd3
   } lsm_mode_e;

   typedef enum logic [1:0] {
      LSM_ST_IDLE   = 2'd0,
      LSM_ST_MOVE   = 2'd1,
      LSM_ST_FINISH = 2'd2
   } lsm_state_e;

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);

   always_comb begin
      cnt = '0;
      for (int i = 0; i < W; i++) begin
         cnt = cnt + CW'(vec[i]);
      end
   end

endmodule

// File: rtl/lsm_lowest_pick.sv
module lsm_lowest_pick #(
   parameter int W  = 16,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [W-1:0]  onehot,
   output logic [IW-1:0] idx,
   output logic          last
);

   logic found;

   always_comb begin
      found  = 1'b0;
      onehot = '0;
      idx    = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i] && !found) begin
            onehot[i] = 1'b1;
            idx       = IW'(i);
            found     = 1'b1;
         end
      end
   end

   assign last = ((vec & ~onehot) == '0);

endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc
   import lsm_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic [AW-1:0] base,
   input  logic [1:0]    mode,
   input  logic [CW-1:0] cnt,
   output logic [AW-1:0] base_al,
   output logic [AW-1:0] start,
   output logic [AW-1:0] wb
);

   localparam int          STEP_SH  = $clog2(WORD_BYTES);
   localparam logic [AW-1:0] STEP   = AW'(WORD_BYTES);
   localparam logic [AW-1:0] LOWMSK = AW'(WORD_BYTES - 1);

   logic [AW-1:0] span;
   lsm_mode_e     m;

   assign base_al = base & ~LOWMSK;
   assign span    = AW'(cnt) << STEP_SH;
   assign m       = lsm_mode_e'(mode);

   always_comb begin
      unique case (m)
         LSM_INC_AFTER:  start = base_al;
         LSM_INC_BEFORE: start = base_al + STEP;
         LSM_DEC_AFTER:  start = base_al - span + STEP;
         LSM_DEC_BEFORE: start = base_al - span;
         default:        start = base_al;
      endcase
      wb = mode[1] ? (base_al - span) : (base_al + span);
   end

endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
   import lsm_pkg::*;
#(
   parameter int AW         = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   localparam int IW        = $clog2(NREG),
   localparam int CW        = $clog2(NREG + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_base,
   input  logic [NREG-1:0] req_mask,
   input  logic [1:0]    req_mode,
   input  logic          req_load,
   input  logic          req_wb,
   output logic          xfer_valid,
   input  logic          xfer_ready,
   output logic [AW-1:0] xfer_addr,
   output logic [IW-1:0] xfer_reg,
   output logic          xfer_load,
   output logic          xfer_seq,
   output logic          done,
   output logic [AW-1:0] wb_value,
   output logic          wb_en
);

   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   generate
      if (NREG < 2 || NREG > 64) begin : g_bad_nreg
         $error("lsm_addr_seq: NREG must lie in 2..64");
      end
      if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("lsm_addr_seq: WORD_BYTES must be a power of two of at least 2");
      end
      if (AW < 8) begin : g_bad_aw
         $error("lsm_addr_seq: AW too small");
      end
   endgenerate

   lsm_state_e      state_q;
   logic [NREG-1:0] rem_q;
   logic [AW-1:0]   addr_q;
   logic [AW-1:0]   wb_q;
   logic            first_q;
   logic            load_q;
   logic            wben_q;

   logic [CW-1:0]   req_cnt;
   logic [AW-1:0]   calc_base;
   logic [AW-1:0]   calc_start;
   logic [AW-1:0]   calc_wb;
   logic [NREG-1:0] pick_oh;
   logic [IW-1:0]   pick_idx;
   logic            pick_last;
   logic            accept;
   logic            step_go;

   lsm_popcount #(.W(NREG), .CW(CW)) u_count (
      .vec (req_mask),
      .cnt (req_cnt)
   );

   lsm_addr_calc #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_calc (
      .base    (req_base),
      .mode    (req_mode),
      .cnt     (req_cnt),
      .base_al (calc_base),
      .start   (calc_start),
      .wb      (calc_wb)
   );

   lsm_lowest_pick #(.W(NREG), .IW(IW)) u_pick (
      .vec    (rem_q),
      .onehot (pick_oh),
      .idx    (pick_idx),
      .last   (pick_last)
   );

   assign req_ready = (state_q == LSM_ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign step_go   = (state_q == LSM_ST_MOVE) && xfer_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LSM_ST_IDLE;
         rem_q   <= '0;
         addr_q  <= '0;
         wb_q    <= '0;
         first_q <= 1'b0;
         load_q  <= 1'b0;
         wben_q  <= 1'b0;
      end else begin
         unique case (state_q)
            LSM_ST_IDLE: begin
               if (accept) begin
                  rem_q   <= req_mask;
                  addr_q  <= calc_start;
                  wb_q    <= calc_wb;
                  first_q <= 1'b1;
                  load_q  <= req_load;
                  wben_q  <= req_wb;
                  state_q <= (req_mask != '0) ? LSM_ST_MOVE : LSM_ST_FINISH;
               end
            end
            LSM_ST_MOVE: begin
               if (step_go) begin
                  rem_q   <= rem_q & ~pick_oh;
                  addr_q  <= addr_q + STEP;
                  first_q <= 1'b0;
                  if (pick_last) begin
                     state_q <= LSM_ST_FINISH;
                  end
               end
            end
            LSM_ST_FINISH: begin
               state_q <= LSM_ST_IDLE;
            end
            default: state_q <= LSM_ST_IDLE;
         endcase
      end
   end

   assign xfer_valid = (state_q == LSM_ST_MOVE);
   assign xfer_addr  = addr_q;
   assign xfer_reg   = pick_idx;
   assign xfer_load  = load_q;
   assign xfer_seq   = !first_q;
   assign done       = (state_q == LSM_ST_FINISH);
   assign wb_value   = wb_q;
   assign wb_en      = wben_q;

   logic unused_base;
   assign unused_base = ^calc_base;

endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
   parameter int AW         = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   parameter int IW         = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [NREG-1:0] req_mask,
   input logic            xfer_valid,
   input logic            xfer_ready,
   input logic [AW-1:0]   xfer_addr,
   input logic [IW-1:0]   xfer_reg,
   input logic            xfer_seq,
   input logic            done,
   input logic [AW-1:0]   wb_value
);

   localparam logic [AW-1:0] LOWMSK = AW'(WORD_BYTES - 1);
   localparam logic [AW-1:0] STEP   = AW'(WORD_BYTES);

   assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready, xfer_valid, done}));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready) |=>
         (xfer_valid && $stable(xfer_addr) && $stable(xfer_reg) && $stable(xfer_seq)));

   assert_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(xfer_valid && xfer_ready) && xfer_valid) |->
         (xfer_addr == $past(xfer_addr) + STEP && xfer_reg > $past(xfer_reg)));

   assert_seq_later_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(xfer_valid && xfer_ready) && xfer_valid) |-> xfer_seq);

   assert_first_nonseq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mask != '0) |=> (xfer_valid && !xfer_seq));

   assert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mask == '0) |=> (done && !xfer_valid));

   assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> ((xfer_addr & LOWMSK) == '0));

   assert_wb_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((wb_value & LOWMSK) == '0));

endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(
   .AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES), .IW(IW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_mask   (req_mask),
   .xfer_valid (xfer_valid),
   .xfer_ready (xfer_ready),
   .xfer_addr  (xfer_addr),
   .xfer_reg   (xfer_reg),
   .xfer_seq   (xfer_seq),
   .done       (done),
   .wb_value   (wb_value)
);

// File: tb/lsm_addr_seq_bench.sv
`timescale 1ns/1ps
module lsm_addr_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_base = '0;
   logic [15:0] req_mask = '0;
   logic [1:0]  req_mode = '0;
   logic        req_load = 1'b0;
   logic        req_wb = 1'b0;
   logic        xfer_valid;
   logic        xfer_ready = 1'b0;
   logic [31:0] xfer_addr;
   logic [3:0]  xfer_reg;
   logic        xfer_load;
   logic        xfer_seq;
   logic        done;
   logic [31:0] wb_value;
   logic        wb_en;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   lsm_addr_seq u_lsm_addr_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_base(req_base), .req_mask(req_mask), .req_mode(req_mode),
      .req_load(req_load), .req_wb(req_wb),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
      .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
      .xfer_load(xfer_load), .xfer_seq(xfer_seq),
      .done(done), .wb_value(wb_value), .wb_en(wb_en)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int next_bit(input logic [15:0] m, input int after);
      for (int i = after + 1; i < 16; i++) begin
         if (m[i]) return i;
      end
      return -1;
   endfunction

   task automatic run_req(input string name, input logic [31:0] base, input logic [15:0] mask,
                          input logic [1:0] mode, input bit ld, input bit wb,
                          input logic [15:0] rdy_pat, input bit spam);
      int          n;
      int          k;
      int          cur;
      bit          got_done;
      bit          last_hs;
      bit          held;
      logic [31:0] al;
      logic [31:0] span;
      logic [31:0] start;
      logic [31:0] exp_wb;
      logic [31:0] h_addr;
      logic [3:0]  h_reg;
      bit          h_seq;
      n     = $countones(mask);
      span  = 32'(n) * 32'd4;
      al    = base & ~32'd3;
      case (mode)
         2'd0: start = al;
         2'd1: start = al + 32'd4;
         2'd2: start = al - span + 32'd4;
         default: start = al - span;
      endcase
      exp_wb = mode[1] ? al - span : al + span;

      @(negedge clk);
      chk(req_ready === 1'b1, {name, " R1 idle ready"}, 32'(req_ready), 32'd1);
      req_base  = base;
      req_mask  = mask;
      req_mode  = mode;
      req_load  = ld;
      req_wb    = wb;
      req_valid = 1'b1;
      @(negedge clk);
      if (spam) begin
         req_mask = ~mask;
         req_base = base + 32'h100;
         req_mode = ~mode;
      end else begin
         req_valid = 1'b0;
      end
      k = 0; cur = -1; got_done = 0; held = 0;
      last_hs = (mask == 16'h0);
      for (int cyc = 0; cyc < 300 && !got_done; cyc++) begin
         if (cyc > 0) @(negedge clk);
         if (spam) chk(req_ready === 1'b0, {name, " R1 busy not ready"}, 32'(req_ready), 32'd0);
         if (held) begin
            chk(xfer_valid === 1'b1 && xfer_addr === h_addr && xfer_reg === h_reg && xfer_seq === h_seq,
                {name, " R6 hold during stall"}, xfer_addr, h_addr);
            held = 0;
         end
         if (done === 1'b1) begin
            chk(last_hs, {name, " R7 done one cycle after last access"}, 32'(k), 32'(n));
            chk(k == n, {name, " R2 access count"}, 32'(k), 32'(n));
            chk(wb_value === exp_wb, {name, " R7 writeback value"}, wb_value, exp_wb);
            chk(wb_en === wb, {name, " R7 writeback flag"}, 32'(wb_en), 32'(wb));
            if (mask == 16'h0) begin
               chk(xfer_valid === 1'b0 && wb_value === al, {name, " R8 empty mask"}, wb_value, al);
            end
            got_done   = 1;
            req_valid  = 1'b0;
            xfer_ready = 1'b0;
         end else begin
            last_hs = 0;
            if (xfer_valid === 1'b1) begin
               xfer_ready = rdy_pat[cyc % 16];
               if (rdy_pat[cyc % 16]) begin
                  cur = next_bit(mask, cur);
                  chk(32'(xfer_reg) == 32'(cur), {name, " R2 register order"}, 32'(xfer_reg), 32'(cur));
                  if (k == 0)
                     chk(xfer_addr === start, {name, " R3 start address"}, xfer_addr, start);
                  else
                     chk(xfer_addr === start + 32'(k) * 32'd4, {name, " R4 address step"},
                         xfer_addr, start + 32'(k) * 32'd4);
                  chk(xfer_seq === (k != 0), {name, " R5 sequential flag"}, 32'(xfer_seq), 32'(k != 0));
                  chk(xfer_load === ld, {name, " R7 load flag"}, 32'(xfer_load), 32'(ld));
                  chk(xfer_addr[1:0] === 2'b00, {name, " R9 alignment"}, xfer_addr, xfer_addr & ~32'd3);
                  k++;
                  last_hs = (k == n);
               end else begin
                  held   = 1;
                  h_addr = xfer_addr;
                  h_reg  = xfer_reg;
                  h_seq  = xfer_seq;
               end
            end else begin
               xfer_ready = 1'b0;
               chk(1'b0, {name, " R2 gap without access or done"}, 32'(k), 32'(n));
            end
         end
      end
      chk(got_done, {name, " R7 done seen"}, 32'(got_done), 32'd1);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready === 1'b1, "reset R1 ready", 32'(req_ready), 32'd1);
      chk(xfer_valid === 1'b0, "reset R2 no access", 32'(xfer_valid), 32'd0);
      chk(done === 1'b0, "reset R7 no done", 32'(done), 32'd0);
   endtask

   task automatic t_inc_after();
      run_req("inc_after", 32'h0000_1000, 16'h00F1, 2'd0, 1'b1, 1'b1, 16'hFFFF, 1'b0);
   endtask

   task automatic t_inc_before();
      run_req("inc_before", 32'h0000_2000, 16'h8001, 2'd1, 1'b0, 1'b1, 16'hFFFF, 1'b0);
   endtask

   task automatic t_dec_after();
      run_req("dec_after", 32'h0000_3000, 16'h0F0F, 2'd2, 1'b1, 1'b0, 16'hAAAA, 1'b0);
   endtask

   task automatic t_dec_before();
      run_req("dec_before", 32'h0000_4000, 16'hFFFF, 2'd3, 1'b0, 1'b1, 16'h3333, 1'b0);
   endtask

   task automatic t_empty();
      run_req("empty_R8", 32'h0000_5000, 16'h0000, 2'd3, 1'b0, 1'b1, 16'hFFFF, 1'b0);
   endtask

   task automatic t_single_top();
      run_req("single_top", 32'h0000_0010, 16'h8000, 2'd2, 1'b1, 1'b1, 16'hFFFF, 1'b0);
   endtask

   task automatic t_unaligned();
      run_req("unaligned_R9", 32'h0000_6003, 16'h0006, 2'd1, 1'b0, 1'b1, 16'hFFFF, 1'b0);
   endtask

   task automatic t_wrap();
      run_req("wrap", 32'h0000_0000, 16'h0003, 2'd3, 1'b1, 1'b1, 16'hFFFF, 1'b0);
   endtask

   task automatic t_busy_ignore();
      run_req("busy_R1", 32'h0000_7000, 16'h0030, 2'd0, 1'b0, 1'b1, 16'h5555, 1'b1);
      @(negedge clk);
      chk(req_ready === 1'b1 && xfer_valid === 1'b0, "busy R1 back to idle, nothing queued",
          32'(xfer_valid), 32'd0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_inc_after();
      t_inc_before();
      t_dec_after();
      t_dec_before();
      t_empty();
      t_single_top();
      t_unaligned();
      t_wrap();
      t_busy_ignore();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule